// File: doc/BRIEF.md
# Unified Funnel Shifter

This block shifts or rotates an N-bit operand by an amount k, where k lies between 0 and N-1, and covers six operation kinds on one datapath. A 3-bit operation code selects logical, arithmetic or rotating movement in either direction. The block is purely combinational. It is meant for an execution unit that needs every shift and rotate kind without paying for six separate shifters.

Internally a front end turns the operand into a 2N-1 bit source field. For right-type operations the operand sits in the low N bits and the fill sits above it. For left-type operations the operand sits in the high N bits and the fill sits below it. An offset, which is k for right-type operations and N-1-k for left-type ones, then drives a chain of log2(N) stages of 2-input multiplexers. Each stage is steered by one offset bit and shrinks the field, so the last stage yields the N-bit result window. N must be a power of two, at least 2.

Top module: `funnel_shifter`

## Requirements
- R1: Operation code 000 (logical left) returns the operand moved k places toward the most significant end, with zeros in the k vacated low positions.
- R2: Operation code 001 (logical right) returns the operand moved k places toward the least significant end, with zeros in the k vacated high positions.
- R3: Operation code 010 (arithmetic left) gives exactly the result of code 000 for every operand and amount.
- R4: Operation code 011 (arithmetic right) moves the operand k places toward the least significant end and fills the k vacated high positions with copies of operand bit N-1.
- R5: Operation code 100 (rotate left) moves the operand k places toward the most significant end and places the k bits pushed out at the top into the k low positions, in the same order.
- R6: Operation code 101 (rotate right) moves the operand k places toward the least significant end and places the k bits pushed out at the bottom into the k high positions, in the same order.
- R7: A shift amount of 0 returns the operand unchanged for every operation code.
- R8: Operation codes 110 and 111 return the operand unchanged whatever the shift amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | N | Operand to be shifted or rotated |
| amt_i | input | log2(N) | Shift amount k |
| op_i | input | 3 | Operation code (see R1 to R8) |
| res_o | output | N | Shifted or rotated result |

## Verification
The assertions check properties of every result as it settles: zero fill for logical shifts, the copied sign bit for the arithmetic right shift, preserved bit count for rotates, and identity for amount 0 and for the pass-through codes. They cannot show where each surviving bit lands or that rotated-out bits come back in order. Only the bench's full sweep shows that. It covers every operation code, every amount and every 8-bit operand, and compares each result with a reference built from plain shift and concatenation operators.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam logic [2:0] OP_LSL  = 3'b000;
  localparam logic [2:0] OP_LSR  = 3'b001;
  localparam logic [2:0] OP_ASL  = 3'b010;
  localparam logic [2:0] OP_ASR  = 3'b011;
  localparam logic [2:0] OP_ROL  = 3'b100;
  localparam logic [2:0] OP_ROR  = 3'b101;

  // Left-type codes place the operand high in the field.
  function automatic logic op_is_left(input logic [2:0] op);
    return (op == OP_LSL) || (op == OP_ASL) || (op == OP_ROL);
  endfunction
endpackage

// File: rtl/fsh_field_build.sv
module fsh_field_build #(
  parameter int N = 8
) (
  input  logic [N-1:0]   opnd_i,
  input  logic [2:0]     op_i,
  output logic [2*N-2:0] field_o
);
  import fsh_pkg::*;

  localparam int FW = 2*N - 1;

  logic [N-2:0] sign_fill;
  assign sign_fill = {(N-1){opnd_i[N-1]}};

  always_comb begin
    case (op_i)
      OP_LSL, OP_ASL: field_o = {opnd_i, {(N-1){1'b0}}};
      OP_ROL:         field_o = {opnd_i, opnd_i[N-1:1]};
      OP_LSR:         field_o = {{(N-1){1'b0}}, opnd_i};
      OP_ASR:         field_o = {sign_fill, opnd_i};
      OP_ROR:         field_o = {opnd_i[N-2:0], opnd_i};
      default:        field_o = FW'(opnd_i);
    endcase
  end
endmodule

// File: rtl/fsh_offset_calc.sv
module fsh_offset_calc #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    op_i,
  output logic [AW-1:0] off_o
);
  import fsh_pkg::*;

  localparam logic [AW-1:0] TOP_OFF = AW'(N - 1);

  always_comb begin
    if (op_is_left(op_i))
      off_o = TOP_OFF - amt_i;
    else if (op_i[2:1] == 2'b11)
      off_o = '0;
    else
      off_o = amt_i;
  end
endmodule

// File: rtl/fsh_mux_stage.sv
module fsh_mux_stage #(
  parameter int OW = 8,
  parameter int SH = 1
) (
  input  logic [OW+SH-1:0] in_i,
  input  logic             sel_i,
  output logic [OW-1:0]    out_o
);
  assign out_o = sel_i ? in_i[SH +: OW] : in_i[OW-1:0];
endmodule

// File: rtl/fsh_window_mux.sv
module fsh_window_mux #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic [2*N-2:0] field_i,
  input  logic [AW-1:0]  off_i,
  output logic [N-1:0]   win_o
);
  // Stage i serves offset bit AW-1-i; the field narrows by 2**bit each stage.
  for (genvar i = 0; i < AW; i++) begin : g_st
    localparam int BIT = AW - 1 - i;
    localparam int SH  = 1 << BIT;
    localparam int OW  = N + SH - 1;
    logic [OW+SH-1:0] lvl_in;
    logic [OW-1:0]    lvl;
    if (i == 0) begin : g_first
      assign lvl_in = field_i;
    end else begin : g_next
      assign lvl_in = g_st[i-1].lvl;
    end
    fsh_mux_stage #(.OW(OW), .SH(SH)) u_stage (
      .in_i (lvl_in),
      .sel_i(off_i[BIT]),
      .out_o(lvl)
    );
  end

  assign win_o = g_st[AW-1].lvl;
endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  opnd_i,
  input  logic [AW-1:0] amt_i,
  input  logic [2:0]    op_i,
  output logic [N-1:0]  res_o
);
  import fsh_pkg::*;

  logic [2*N-2:0] field;
  logic [AW-1:0]  off;

  fsh_field_build #(.N(N)) u_field (
    .opnd_i (opnd_i),
    .op_i   (op_i),
    .field_o(field)
  );

  fsh_offset_calc #(.N(N), .AW(AW)) u_off (
    .amt_i(amt_i),
    .op_i (op_i),
    .off_o(off)
  );

  fsh_window_mux #(.N(N), .AW(AW)) u_win (
    .field_i(field),
    .off_i  (off),
    .win_o  (res_o)
  );

  // Result checks on settled values
  logic [N-1:0] low_mask;
  logic [N-1:0] high_mask;
  assign low_mask  = (N'(1) << amt_i) - N'(1);
  assign high_mask = ~({N{1'b1}} >> amt_i);

  always_comb begin
    if (op_i == OP_LSL)
      AST_LSL_ZERO_FILL: assert ((res_o & low_mask) == '0); // R1
    if (op_i == OP_LSR)
      AST_LSR_ZERO_FILL: assert ((res_o & high_mask) == '0); // R2
    if (op_i == OP_ASL)
      AST_ASL_ZERO_FILL: assert ((res_o & low_mask) == '0); // R3
    if (op_i == OP_ASR)
      AST_ASR_SIGN_KEEP: assert (res_o[N-1] == opnd_i[N-1]); // R4
    if (op_i == OP_ROL)
      AST_ROL_POPCOUNT: assert ($countones(res_o) == $countones(opnd_i)); // R5
    if (op_i == OP_ROR)
      AST_ROR_POPCOUNT: assert ($countones(res_o) == $countones(opnd_i)); // R6
    if (amt_i == '0)
      AST_ZERO_AMT_IDENT: assert (res_o == opnd_i); // R7
    if (op_i[2:1] == 2'b11)
      AST_PASS_IDENT: assert (res_o == opnd_i); // R8
  end
endmodule

// File: tb/funnel_shifter_tb.sv
module funnel_shifter_tb;
  localparam int N  = 8;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  opnd;
  logic [AW-1:0] amt;
  logic [2:0]    op;
  logic [N-1:0]  res;
  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  funnel_shifter #(.N(N)) u_dut (
    .opnd_i(opnd),
    .amt_i (amt),
    .op_i  (op),
    .res_o (res)
  );

  function automatic logic [N-1:0] ref_model(input logic [N-1:0] a,
                                             input int k, input logic [2:0] o);
    case (o)
      3'b000, 3'b010: return a << k;
      3'b001:         return a >> k;
      3'b011:         return N'($signed(a) >>> k);
      3'b100:         return (a << k) | (a >> (N - k));
      3'b101:         return (a >> k) | (a << (N - k));
      default:        return a;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] o, input int k);
    if (o[2:1] == 2'b11) return "R8";
    if (k == 0) return "R7";
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp);
    total++;
    if (res !== exp) begin
      bad++;
      $display("FAIL %s op=%b k=%0d a=%h actual=%h expected=%h",
               req, op, amt, opnd, res, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] a, input int k, input logic [2:0] o);
    @(posedge clk);
    opnd = a;
    amt  = AW'(k);
    op   = o;
    @(negedge clk);
  endtask

  initial begin
    opnd = '0; amt = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Directed cases: R1 R2 R3 R4 R5 R6 on a known pattern
    apply(8'b1011_0001, 1, 3'b000); check("R1", 8'b0110_0010);
    apply(8'b1011_0001, 1, 3'b001); check("R2", 8'b0101_1000);
    apply(8'b1011_0001, 1, 3'b010); check("R3", 8'b0110_0010);
    apply(8'b1011_0001, 1, 3'b011); check("R4", 8'b1101_1000);
    apply(8'b1011_0001, 3, 3'b100); check("R5", 8'b1000_1101);
    apply(8'b1011_0001, 3, 3'b101); check("R6", 8'b0011_0110);
    apply(8'b1000_0000, 7, 3'b011); check("R4", 8'b1111_1111);
    apply(8'b0101_1010, 5, 3'b110); check("R8", 8'b0101_1010);
    apply(8'b0101_1010, 7, 3'b111); check("R8", 8'b0101_1010);
    // Exhaustive sweep: every code, amount and operand (covers R7 at k=0)
    for (int o = 0; o < 8; o++)
      for (int k = 0; k < N; k++)
        for (int a = 0; a < (1 << N); a++) begin
          apply(N'(a), k, 3'(o));
          check(req_of(3'(o), k), ref_model(N'(a), k, 3'(o)));
        end
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule